// File: doc/BRIEF.md
# High-Voltage Programming Entry Sequencer

This block sits on the host side of a programming link. It takes a target microcontroller into high-voltage serial programming mode and then runs one full-device erase. It has outputs for the target's reset line, a serial clock, three mode-select pins with separate output enables, and the enable of an external high-voltage switch. Every wait is counted in system-clock cycles. Each minimum time is given in nanoseconds and rounded up to whole cycles, so no wait is ever shorter than its minimum.

After mode entry the sequencer asks an external bit shifter to send the erase instruction. The handshake is a one-cycle start pulse with a command code, answered by a done pulse. The sequencer then watches the target's data-out line until it goes high, which marks the end of the erase. Next it sends a no-operation instruction and pulses `done_o`. The target is then held in programming mode until an abort arrives. If the erase does not finish within a bounded time, the sequencer shuts down and raises an error flag. An abort at any point first removes the high voltage and only then returns the other pins to idle.

Top module: `hvp_entry_seq`

## Requirements
- R1: After `start_i` in state IDLE, `rst_low_o` goes high. While it is high and `sel_oe_o` is 000, `sci_o` makes exactly `SCI_PULSES` (default 6) full high/low pulses. It is low again before any select pin is driven.
- R2: The select pins are then driven to the pattern 000 (`sel_oe_o` = 111, `sel_o` = 000) for at least ceil(`SETUP_NS`·`CLK_MHZ`/1000) cycles before `hv_en_o` rises. `hv_en_o` is never high together with `rst_low_o`.
- R3: From the cycle `hv_en_o` rises, the select pins keep the same drive for at least ceil(`HOLD_NS`·`CLK_MHZ`/1000) cycles.
- R4: After that hold, only select bit 2 is released: `sel_oe_o` becomes 011 and keeps that value while the high voltage stays applied.
- R5: The first instruction start (`shf_start_o` with `shf_cmd_o` = 1, the erase code) comes at least ceil(`SETTLE_NS`·`CLK_MHZ`/1000) cycles after select bit 2 is released.
- R6: After the shifter reports the erase done, the sequencer waits for `sdo_i` high. Only then does it start the no-operation code (`shf_cmd_o` = 2). When that is done, `done_o` pulses for exactly one cycle, the state becomes READY (code 8) and `hv_en_o` stays high.
- R7: If `sdo_i` stays low for more than `POLL_MAX` cycles after the erase finishes, the sequencer drops all pins to idle and enters ERROR (code 10) with `err_o` high. A later `start_i` clears `err_o` and begins the sequence again.
- R8: `abort_i` in any active state moves to DROP (code 9). In that cycle `hv_en_o` is low while `rst_low_o` and `sel_oe_o` keep their previous values. One cycle later every output is idle and the state is IDLE (code 0).
- R9: After reset, every output is low and `state_o` is IDLE (code 0).
- R10: `start_i` has no effect while a sequence is running or in READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the entry and erase sequence |
| abort_i | input | 1 | Abandon the sequence and power down the target pins |
| sdo_i | input | 1 | Target data-out level, read while polling |
| shf_done_i | input | 1 | Shifter finished the current instruction |
| rst_low_o | output | 1 | Pull the target reset line low |
| hv_en_o | output | 1 | Switch the high voltage onto the reset line |
| sci_o | output | 1 | Serial clock to the target |
| sel_o | output | 3 | Mode-select pin levels |
| sel_oe_o | output | 3 | Mode-select output enables, one per pin |
| shf_start_o | output | 1 | One-cycle request to the shifter |
| shf_cmd_o | output | 2 | Instruction code: 1 erase, 2 no-operation |
| done_o | output | 1 | One-cycle pulse when the erase flow completes |
| err_o | output | 1 | Erase poll timed out |
| state_o | output | 4 | Current sequencer state, for debug |

## Verification
The bench keeps the default 125 MHz clock figure and the real minimum times. The setup and hold waits are therefore 13 cycles each and the settle wait is 6250 cycles, so every timing margin is measured at true size. It sets `POLL_MAX` to 300 cycles, so the timeout path into the error state and the restart from it fit into a short run. A model shifter answers each start after three cycles. A model target raises data-out after a chosen delay, or never.

// File: rtl/hvp_pkg.sv
package hvp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_TOGGLE = 4'd1,
    ST_SETUP  = 4'd2,
    ST_HOLD   = 4'd3,
    ST_SETTLE = 4'd4,
    ST_ERASE  = 4'd5,
    ST_POLL   = 4'd6,
    ST_NOP    = 4'd7,
    ST_READY  = 4'd8,
    ST_DROP   = 4'd9,
    ST_ERROR  = 4'd10
  } hvp_state_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_ERASE = 2'd1,
    CMD_NOP   = 2'd2
  } hvp_cmd_e;

  // minimum time in ns -> whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/hvp_delay_timer.sv
module hvp_delay_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R5: a running wait shortens by exactly one cycle per clock
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/hvp_sci_gen.sv
module hvp_sci_gen #(
  parameter int unsigned HALF   = 2,
  parameter int unsigned PULSES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sci,
  output logic fin
);

  localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned EW = $clog2(PULSES + 1);

  logic          sci_q, sci_d;
  logic [HW-1:0] half_q, half_d;
  logic [EW-1:0] edge_q, edge_d;

  assign fin = (edge_q == EW'(PULSES));

  always_comb begin
    sci_d  = sci_q;
    half_d = half_q;
    edge_d = edge_q;
    if (!en) begin
      sci_d  = 1'b0;
      half_d = '0;
      edge_d = '0;
    end else if (half_q == HW'(HALF - 1)) begin
      half_d = '0;
      if (!fin) begin
        sci_d = ~sci_q;
        if (sci_q) edge_d = edge_q + 1'b1;
      end
    end else begin
      half_d = half_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_q  <= 1'b0;
      half_q <= '0;
      edge_q <= '0;
    end else begin
      sci_q  <= sci_d;
      half_q <= half_d;
      edge_q <= edge_d;
    end
  end

  assign sci = sci_q;

  // R1: the clock rests low once the pulse count is reached
  p_sci_rest_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fin) |=> !sci_q);
  p_pulse_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= EW'(PULSES));

endmodule

// File: rtl/hvp_entry_seq.sv
module hvp_entry_seq
  import hvp_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned SETUP_NS   = 100,
  parameter int unsigned HOLD_NS    = 100,
  parameter int unsigned SETTLE_NS  = 50000,
  parameter int unsigned SCI_HALF   = 2,
  parameter int unsigned SCI_PULSES = 6,
  parameter int unsigned POLL_MAX   = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       sdo_i,
  input  logic       shf_done_i,
  output logic       rst_low_o,
  output logic       hv_en_o,
  output logic       sci_o,
  output logic [2:0] sel_o,
  output logic [2:0] sel_oe_o,
  output logic       shf_start_o,
  output logic [1:0] shf_cmd_o,
  output logic       done_o,
  output logic       err_o,
  output logic [3:0] state_o
);

  localparam int unsigned SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_MHZ);
  localparam int unsigned HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_MHZ);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
  localparam int unsigned MAX_A      = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int unsigned MAX_B      = (SETTLE_CYC > POLL_MAX) ? SETTLE_CYC : POLL_MAX;
  localparam int unsigned MAX_WAIT   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW         = $clog2(MAX_WAIT + 1);
  localparam logic [2:0]  MODE_PAT   = 3'b000;
  localparam logic [2:0]  OE_ALL     = 3'b111;
  localparam logic [2:0]  OE_NO_B2   = 3'b011;

  hvp_state_e    state_q, state_d;
  logic          err_q, err_d;
  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          sci_en, sci_fin;
  logic          rst_low_q, rst_low_d;
  logic          hv_q, hv_d;
  logic [2:0]    oe_q, oe_d;
  logic          start_q, start_d;
  hvp_cmd_e      cmd_q, cmd_d;
  logic          done_q, done_d;

  hvp_delay_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  assign sci_en = (state_q == ST_TOGGLE);

  hvp_sci_gen #(.HALF(SCI_HALF), .PULSES(SCI_PULSES)) u_sci (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (sci_en),
    .sci   (sci_o),
    .fin   (sci_fin)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (abort_i && state_q != ST_IDLE && state_q != ST_DROP && state_q != ST_ERROR) begin
      state_d = ST_DROP;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (start_i) state_d = ST_TOGGLE;
        ST_TOGGLE: if (sci_fin) begin
                     state_d = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC);
                   end
        ST_SETUP:  if (tmr_exp) begin
                     state_d = ST_HOLD; tmr_load = 1'b1; tmr_val = TW'(HOLD_CYC);
                   end
        ST_HOLD:   if (tmr_exp) begin
                     state_d = ST_SETTLE; tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC);
                   end
        ST_SETTLE: if (tmr_exp) state_d = ST_ERASE;
        ST_ERASE:  if (shf_done_i) begin
                     state_d = ST_POLL; tmr_load = 1'b1; tmr_val = TW'(POLL_MAX);
                   end
        ST_POLL:   if (sdo_i) state_d = ST_NOP;
                   else if (tmr_exp) begin
                     state_d = ST_DROP; err_d = 1'b1;
                   end
        ST_NOP:    if (shf_done_i) state_d = ST_READY;
        ST_READY:  state_d = ST_READY;
        ST_DROP:   state_d = err_q ? ST_ERROR : ST_IDLE;
        ST_ERROR:  if (start_i) begin
                     state_d = ST_TOGGLE; err_d = 1'b0;
                   end else if (abort_i) begin
                     state_d = ST_IDLE; err_d = 1'b0;
                   end
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  // pin levels follow the state being entered; DROP removes only the high voltage
  always_comb begin
    rst_low_d = 1'b0;
    hv_d      = 1'b0;
    oe_d      = '0;
    unique case (state_d)
      ST_TOGGLE: rst_low_d = 1'b1;
      ST_SETUP:  begin rst_low_d = 1'b1; oe_d = OE_ALL; end
      ST_HOLD:   begin hv_d = 1'b1; oe_d = OE_ALL; end
      ST_SETTLE, ST_ERASE, ST_POLL, ST_NOP, ST_READY:
                 begin hv_d = 1'b1; oe_d = OE_NO_B2; end
      ST_DROP:   begin rst_low_d = rst_low_q; oe_d = oe_q; end
      default:   ;
    endcase
    start_d = (state_d == ST_ERASE && state_q != ST_ERASE) ||
              (state_d == ST_NOP   && state_q != ST_NOP);
    cmd_d   = cmd_q;
    if (state_d == ST_IDLE)                        cmd_d = CMD_NONE;
    else if (start_d && state_d == ST_ERASE)       cmd_d = CMD_ERASE;
    else if (start_d)                              cmd_d = CMD_NOP;
    done_d  = (state_q == ST_NOP) && (state_d == ST_READY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      err_q     <= 1'b0;
      rst_low_q <= 1'b0;
      hv_q      <= 1'b0;
      oe_q      <= '0;
      start_q   <= 1'b0;
      cmd_q     <= CMD_NONE;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      err_q     <= err_d;
      rst_low_q <= rst_low_d;
      hv_q      <= hv_d;
      oe_q      <= oe_d;
      start_q   <= start_d;
      cmd_q     <= cmd_d;
      done_q    <= done_d;
    end
  end

  assign rst_low_o   = rst_low_q;
  assign hv_en_o     = hv_q;
  assign sel_o       = MODE_PAT;
  assign sel_oe_o    = oe_q;
  assign shf_start_o = start_q;
  assign shf_cmd_o   = cmd_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign state_o     = state_q;

  p_hv_rst_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_en_o && rst_low_o));
  p_drive_before_hv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en_o) |-> ($past(sel_oe_o) == OE_ALL && $past(rst_low_o)));
  p_hold_full_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv_en_o) |=> (sel_oe_o == OE_ALL));
  p_release_bit2_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en_o && sel_oe_o != $past(sel_oe_o)) |-> (sel_oe_o == OE_NO_B2));
  p_nop_needs_sdo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_start_o && shf_cmd_o == CMD_NOP) |-> $past(sdo_i));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_err_no_hv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !hv_en_o);
  p_hv_drops_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_en_o) |-> (sel_oe_o == $past(sel_oe_o) && rst_low_o == $past(rst_low_o)));

endmodule

// File: tb/hvp_entry_seq_test.sv
module hvp_entry_seq_test;

  localparam int POLL_LIM = 300;
  localparam int SETUP_MIN = 13;
  localparam int HOLD_MIN = 13;
  localparam int SETTLE_MIN = 6250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, abort_i = 1'b0, sdo_i = 1'b0, shf_done_i = 1'b0;
  logic rst_low_o, hv_en_o, sci_o, shf_start_o, done_o, err_o;
  logic [2:0] sel_o, sel_oe_o;
  logic [1:0] shf_cmd_o;
  logic [3:0] state_o;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  hvp_entry_seq #(.POLL_MAX(POLL_LIM)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .sdo_i(sdo_i), .shf_done_i(shf_done_i), .rst_low_o(rst_low_o),
    .hv_en_o(hv_en_o), .sci_o(sci_o), .sel_o(sel_o), .sel_oe_o(sel_oe_o),
    .shf_start_o(shf_start_o), .shf_cmd_o(shf_cmd_o), .done_o(done_o),
    .err_o(err_o), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic mon_clr = 1'b0;
  int cyc = 0, m_rises, rises_at_drive, t_drive, t_hv, t_rel, oe_rel, t_er, t_nop;
  int n_er, n_nop, n_done, t_err, sel_at_drive, sci_at_drive;
  logic sdo_at_nop;
  logic p_sci = 1'b0, p_hv = 1'b0, p_err = 1'b0;
  logic [2:0] p_oe = 3'b000;

  always @(negedge clk) begin
    if (mon_clr) begin
      m_rises = 0; rises_at_drive = -1; t_drive = -1; t_hv = -1; t_rel = -1; oe_rel = -1;
      t_er = -1; t_nop = -1; n_er = 0; n_nop = 0; n_done = 0; t_err = -1;
      sel_at_drive = -1; sci_at_drive = -1; sdo_at_nop = 1'b0;
    end else begin
      if (sci_o && !p_sci && rst_low_o && sel_oe_o == 3'b000) m_rises++;
      if (sel_oe_o == 3'b111 && p_oe == 3'b000) begin
        t_drive = cyc; rises_at_drive = m_rises; sel_at_drive = sel_o; sci_at_drive = sci_o;
      end
      if (hv_en_o && !p_hv) t_hv = cyc;
      if (hv_en_o && p_oe == 3'b111 && sel_oe_o != 3'b111 && t_rel < 0) begin
        t_rel = cyc; oe_rel = sel_oe_o;
      end
      if (shf_start_o && shf_cmd_o == 2'd1) begin t_er = cyc; n_er++; end
      if (shf_start_o && shf_cmd_o == 2'd2) begin t_nop = cyc; n_nop++; sdo_at_nop = sdo_i; end
      if (done_o) n_done++;
      if (err_o && !p_err) t_err = cyc;
    end
    p_sci = sci_o; p_hv = hv_en_o; p_err = err_o; p_oe = sel_oe_o;
    cyc++;
  end

  // ---------------- model shifter and target ----------------
  logic tgt_answers = 1'b1;
  int   tgt_delay = 40;

  initial begin
    forever begin
      @(negedge clk);
      if (shf_start_o) begin
        automatic logic [1:0] c = shf_cmd_o;
        repeat (3) @(negedge clk);
        shf_done_i = 1'b1;
        @(negedge clk);
        shf_done_i = 1'b0;
        if (c == 2'd1 && tgt_answers) begin
          repeat (tgt_delay) @(negedge clk);
          sdo_i = 1'b1;
        end else if (c == 2'd2) begin
          sdo_i = 1'b0;
        end
      end
    end
  end

  task automatic clear_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_state(input int code, input int lim);
    for (int i = 0; i < lim && state_o != code[3:0]; i++) @(negedge clk);
  endtask

  task automatic return_idle();
    abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
    repeat (3) @(negedge clk);
    sdo_i = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(state_o == 4'd0, "R9", "state after reset", state_o, 0);
    chk({rst_low_o, hv_en_o, sci_o, sel_oe_o, shf_start_o, done_o, err_o} == '0,
        "R9", "outputs after reset", {rst_low_o, hv_en_o, sci_o, sel_oe_o}, 0);
  endtask

  task automatic t_full_erase();
    clear_mon();
    tgt_answers = 1'b1; tgt_delay = 40;
    pulse_start();
    chk(rst_low_o == 1'b1, "R1", "reset pulled low after start", rst_low_o, 1);
    wait_state(4, 2000);
    // R10: start during the settle wait is ignored
    pulse_start();
    chk(state_o == 4'd4, "R10", "state after start while busy", state_o, 4);
    wait_state(8, 12000);
    repeat (5) @(negedge clk);
    chk(rises_at_drive == 6, "R1", "clock pulses before select drive", rises_at_drive, 6);
    chk(sci_at_drive == 0, "R1", "clock low at select drive", sci_at_drive, 0);
    chk(sel_at_drive == 0, "R2", "select pattern", sel_at_drive, 0);
    chk(t_hv - t_drive >= SETUP_MIN, "R2", "setup cycles before high voltage", t_hv - t_drive, SETUP_MIN);
    chk(t_rel - t_hv >= HOLD_MIN, "R3", "hold cycles after high voltage", t_rel - t_hv, HOLD_MIN);
    chk(oe_rel == 3, "R4", "enables after release", oe_rel, 3);
    chk(t_er - t_rel >= SETTLE_MIN, "R5", "settle cycles before erase", t_er - t_rel, SETTLE_MIN);
    chk(n_er == 1 && n_nop == 1, "R6", "erase then nop starts", n_er * 10 + n_nop, 11);
    chk(t_nop > t_er && sdo_at_nop == 1'b1, "R6", "nop issued with data-out high", sdo_at_nop, 1);
    chk(n_done == 1, "R6", "done pulses", n_done, 1);
    chk(state_o == 4'd8 && hv_en_o == 1'b1, "R6", "ready holds high voltage", {state_o, hv_en_o}, 17);
    chk(sel_oe_o == 3'b011, "R4", "bit 2 stays released in ready", sel_oe_o, 3);
    // R10: start in ready is ignored
    pulse_start();
    repeat (2) @(negedge clk);
    chk(state_o == 4'd8 && n_er == 1, "R10", "ready ignores start", state_o, 8);
    return_idle();
  endtask

  task automatic t_abort();
    clear_mon();
    pulse_start();
    wait_state(4, 2000);
    repeat (20) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(hv_en_o == 1'b0, "R8", "high voltage off first", hv_en_o, 0);
    chk(sel_oe_o == 3'b011, "R8", "select drive kept in drop", sel_oe_o, 3);
    chk(state_o == 4'd9, "R8", "drop state code", state_o, 9);
    @(negedge clk);
    chk({rst_low_o, hv_en_o, sci_o, sel_oe_o, shf_start_o} == '0, "R8", "all idle after drop",
        {rst_low_o, hv_en_o, sel_oe_o}, 0);
    chk(state_o == 4'd0 && err_o == 1'b0, "R8", "back in idle", state_o, 0);
  endtask

  task automatic t_timeout();
    clear_mon();
    tgt_answers = 1'b0;
    sdo_i = 1'b0;
    pulse_start();
    wait_state(10, 12000);
    repeat (2) @(negedge clk);
    chk(err_o == 1'b1 && state_o == 4'd10, "R7", "error state on timeout", state_o, 10);
    chk(hv_en_o == 1'b0 && sel_oe_o == 3'b000 && rst_low_o == 1'b0, "R7", "pins idle in error",
        {hv_en_o, sel_oe_o}, 0);
    chk(t_err - t_er >= POLL_LIM, "R7", "poll cycles before error", t_err - t_er, POLL_LIM);
    chk(n_nop == 0, "R6", "no nop without data-out", n_nop, 0);
    pulse_start();
    chk(err_o == 1'b0 && state_o == 4'd1 && rst_low_o == 1'b1, "R7", "restart from error",
        {err_o, state_o}, 1);
    tgt_answers = 1'b1;
    return_idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_erase();
    t_abort();
    t_timeout();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule